// File: doc/BRIEF.md
# Programmable Priority Interrupt Resolver

This block holds a table of programmable priority slots. Each slot names one interrupt source and carries a valid flag. Every cycle it scans the table and finds two winners: the highest-priority active fast-class (FIQ) source and the highest-priority active normal-class (IRQ) source. Both winners are packed into one 32-bit word, which software reads to learn which handler to run for each interrupt class.

Pending and mask state live in a neighbouring routing controller. That controller supplies two inputs: `src_active`, which already combines pending and unmasked, and `src_is_fiq`, which gives the class of each source. The slots and the winner word are reached through a simple register port with byte addresses. Writes take effect at the clock edge. A read returns its data on the cycle after the address is presented.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset every slot reads as zero, so every slot is invalid, and the winner word reads 0x003F003F.
- R2: A slot write keeps only data bit 31 (valid) and bits 5:0 (source ID); all other bits read back as zero. Slot k is at byte offset 0x1C+4k for k below 32, and at 0xB0+4(k-32) for k from 32 to 39.
- R3: A slot takes part in the search only when its valid bit is set and its source ID is below 40.
- R4: When several qualifying active sources of the same class exist, the winner is the one named by the lowest-numbered slot.
- R5: A source counts only when its `src_active` bit is 1. Its class is FIQ when its `src_is_fiq` bit is 1 and IRQ when that bit is 0.
- R6: In the winner word, bit 15 flags that an FIQ winner was found and bits 5:0 hold its source ID. Bit 31 flags that an IRQ winner was found and bits 21:16 hold its ID. All other bits are zero.
- R7: With no FIQ winner, bits 15:0 read 0x003F. With no IRQ winner, bits 31:16 read 0x003F.
- R8: The winner word is at offset 0x18 and is read-only: writes there change nothing. Its value is computed from the slots and inputs present in the cycle the address is presented.
- R9: Offsets that map to no slot, and offsets that are not word-aligned, read as zero; writes to them change nothing.
- R10: `rd_data` presents, one clock after an address is applied, the contents of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_active | input | 40 | Per-source pending-and-unmasked flag |
| src_is_fiq | input | 40 | Per-source class, 1 = FIQ, 0 = IRQ |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for the previous cycle's address |

## Verification
The search is tried with:
- a single active source in the lowest slot, which shows the basic packing;
- two active sources of the same class, first both and then one dropped, which shows that the lower slot wins;
- two sources of opposite class, which shows that both halves of the word fill independently;
- a lone FIQ source in the last slot, which checks the upper bank of addresses.

Invalid slots and slots with out-of-range IDs are offered every source active, so any leak shows as a false winner. Writes to the winner word, to gap offsets and to misaligned offsets are followed by readbacks of the slots they could have hit.

// File: rtl/irq_prio_resolver.sv
`timescale 1ns/1ps
module irq_prio_resolver #(
  parameter int NUM_SLOTS = 40,
  parameter int NUM_SRC   = 40,
  parameter int ID_W      = 6,
  parameter int ADDR_W    = 8,
  parameter int LO_COUNT  = 32,
  parameter int LO_BASE   = 'h1C,
  parameter int HI_BASE   = 'hB0,
  parameter int HP_OFFS   = 'h18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_active,
  input  logic [NUM_SRC-1:0] src_is_fiq,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        rd_data
);
  localparam int IDX_W = $clog2(NUM_SLOTS);
  localparam int HI_COUNT = NUM_SLOTS - LO_COUNT;
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_BASE);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_BASE);
  localparam logic [ADDR_W-1:0] HP_A = ADDR_W'(HP_OFFS);
  localparam logic [ADDR_W-3:0] LO_N = (ADDR_W-2)'(LO_COUNT);
  localparam logic [ADDR_W-3:0] HI_N = (ADDR_W-2)'(HI_COUNT);
  localparam logic [ID_W:0]     SRC_LIM = (ID_W+1)'(NUM_SRC);
  localparam logic [ID_W-1:0]   NO_ID = '1;

  logic [NUM_SLOTS-1:0][ID_W:0] slot_q;

  logic [ADDR_W-1:0] lo_off, hi_off;
  logic              lo_hit, hi_hit, slot_hit, hp_hit;
  logic [IDX_W-1:0]  slot_idx;

  assign lo_off   = reg_addr - LO_A;
  assign hi_off   = reg_addr - HI_A;
  assign lo_hit   = (reg_addr >= LO_A) && (lo_off[ADDR_W-1:2] < LO_N) && (reg_addr[1:0] == 2'b00);
  assign hi_hit   = (reg_addr >= HI_A) && (hi_off[ADDR_W-1:2] < HI_N) && (reg_addr[1:0] == 2'b00);
  assign slot_hit = lo_hit || hi_hit;
  assign hp_hit   = (reg_addr == HP_A);
  assign slot_idx = lo_hit ? IDX_W'(lo_off[ADDR_W-1:2])
                           : IDX_W'(LO_COUNT) + IDX_W'(hi_off[ADDR_W-1:2]);

  always_ff @(posedge clk) begin
    if (!rst_n) slot_q <= '0;
    else if (reg_wr && slot_hit) slot_q[slot_idx] <= {reg_wdata[31], reg_wdata[ID_W-1:0]};
  end

  logic            fiq_found, irq_found;
  logic [ID_W-1:0] fiq_id, irq_id;

  always_comb begin
    fiq_found = 1'b0;
    irq_found = 1'b0;
    fiq_id    = NO_ID;
    irq_id    = NO_ID;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (slot_q[s][ID_W] && ({1'b0, slot_q[s][ID_W-1:0]} < SRC_LIM)) begin
        if (src_active[slot_q[s][ID_W-1:0]]) begin
          if (src_is_fiq[slot_q[s][ID_W-1:0]]) begin
            fiq_found = 1'b1;
            fiq_id    = slot_q[s][ID_W-1:0];
          end else begin
            irq_found = 1'b1;
            irq_id    = slot_q[s][ID_W-1:0];
          end
        end
      end
    end
  end

  logic [31:0] hp_word, slot_word;
  assign hp_word   = {irq_found, (15-ID_W)'(0), irq_id, fiq_found, (15-ID_W)'(0), fiq_id};
  assign slot_word = {slot_q[slot_idx][ID_W], (31-ID_W)'(0), slot_q[slot_idx][ID_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n)        rd_data <= '0;
    else if (hp_hit)   rd_data <= hp_word;
    else if (slot_hit) rd_data <= slot_word;
    else               rd_data <= '0;
  end

  // R5
  fiq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_found |-> ({1'b0, fiq_id} < SRC_LIM) && src_active[fiq_id] && src_is_fiq[fiq_id]);
  // R5
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_found |-> ({1'b0, irq_id} < SRC_LIM) && src_active[irq_id] && !src_is_fiq[irq_id]);
  // R7
  no_fiq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(src_active & src_is_fiq)) |-> !fiq_found);
  // R8
  hp_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && hp_hit) |=> $stable(slot_q));
  // R9
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_hit && !hp_hit) |=> (rd_data == 32'h0));
endmodule

// File: tb/irq_prio_resolver_bench.sv
`timescale 1ns/1ps
module irq_prio_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] src_active = '0;
  logic [39:0] src_is_fiq = '0;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd_data;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_prio_resolver u_irq_prio_resolver (
    .clk(clk), .rst_n(rst_n), .src_active(src_active), .src_is_fiq(src_is_fiq),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .rd_data(rd_data));

  function automatic logic [7:0] slot_addr(int k);
    return (k < 32) ? 8'(8'h1C + 4*k) : 8'(8'hB0 + 4*(k-32));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(slot_addr(0), v);  check("R1 slot0", v, 32'h0);
    rd(slot_addr(31), v); check("R1 slot31", v, 32'h0);
    rd(slot_addr(39), v); check("R1 slot39", v, 32'h0);
    src_active = '1;
    rd(8'h18, v); check("R1 R7 hp after reset", v, 32'h003F003F);
    src_active = '0;
  endtask

  task automatic t_fields;
    logic [31:0] v;
    wr(slot_addr(5), 32'hFFFFFFFF);
    rd(slot_addr(5), v); check("R2 keep bits", v, 32'h8000003F);
    wr(slot_addr(5), 32'h7FFFFFC0);
    rd(slot_addr(5), v); check("R2 drop bits", v, 32'h0);
    wr(slot_addr(35), 32'hFFFFFFFF);
    rd(slot_addr(35), v); check("R2 upper bank", v, 32'h8000003F);
  endtask

  task automatic t_qualify;
    logic [31:0] v;
    src_active = '1; src_is_fiq = '0;
    wr(slot_addr(0), 32'h00000003);
    rd(8'h18, v); check("R3 invalid slot", v, 32'h003F003F);
    wr(slot_addr(0), 32'h8000002D);
    rd(8'h18, v); check("R3 id out of range", v, 32'h003F003F);
    wr(slot_addr(0), 32'h80000003);
    rd(8'h18, v); check("R3 valid slot", v, 32'h8003003F);
    wr(slot_addr(0), 32'h0);
    src_active = '0;
  endtask

  task automatic t_order;
    logic [31:0] v;
    wr(slot_addr(2), 32'h8000000A);
    wr(slot_addr(7), 32'h80000004);
    src_active = 40'h0;
    rd(8'h18, v); check("R5 nothing active", v, 32'h003F003F);
    src_active = (40'h1 << 10) | (40'h1 << 4);
    rd(8'h18, v); check("R4 lower slot wins", v, 32'h800A003F);
    src_active = 40'h1 << 4;
    rd(8'h18, v); check("R4 next slot", v, 32'h8004003F);
  endtask

  task automatic t_class;
    logic [31:0] v;
    src_active = (40'h1 << 10) | (40'h1 << 4);
    src_is_fiq = 40'h1 << 10;
    rd(8'h18, v); check("R5 R6 both classes", v, 32'h8004800A);
    wr(slot_addr(39), 32'h80000027);
    src_active = 40'h1 << 39; src_is_fiq = 40'h1 << 39;
    rd(8'h18, v); check("R6 R7 fiq slot39", v, 32'h003F8027);
  endtask

  task automatic t_readonly;
    logic [31:0] v;
    wr(8'h18, 32'h00000000);
    rd(8'h18, v); check("R8 hp unchanged", v, 32'h003F8027);
    rd(slot_addr(2), v); check("R8 slot2 unchanged", v, 32'h8000000A);
    @(negedge clk);
    reg_addr = 8'h18; src_active = 40'h1 << 4; src_is_fiq = '0;
    @(negedge clk);
    check("R8 R10 same-cycle inputs", rd_data, 32'h8004003F);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(8'h9C, 32'hFFFFFFFF);
    wr(8'h1D, 32'hFFFFFFFF);
    wr(8'hD0, 32'hFFFFFFFF);
    rd(8'h9C, v); check("R9 gap offset", v, 32'h0);
    rd(8'h1D, v); check("R9 misaligned", v, 32'h0);
    rd(8'hD0, v); check("R9 past end", v, 32'h0);
    rd(slot_addr(0), v); check("R9 slot0 untouched", v, 32'h0);
    rd(slot_addr(32), v); check("R9 slot32 untouched", v, 32'h0);
    @(negedge clk); reg_addr = slot_addr(7);
    @(negedge clk); check("R10 one-cycle read", rd_data, 32'h80000004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fields();
    t_qualify();
    t_order();
    t_class();
    t_readonly();
    t_unmapped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule